// File: doc/BRIEF.md
# Masked Multi-Source Interrupt Level Encoder

This block is a system interrupt controller. It takes level-sensitive requests from thirty-one sources: onboard devices, seven expansion-bus request lines, seven backplane-bus request lines and four asynchronous error sources. Each source has its own mask bit. Several sources share one priority level, so one level cannot name a single source, and that is why masking works per source. The unmasked requests are reduced to a 4-bit processor priority level. The output is the highest level that is active, and zero means that nothing is pending.

The host works through a small register port. In any cycle it can pulse a write to the mask-set alias, to the mask-clear alias, or to both. Only the data bits that are 1 act on the mask. A read-select input chooses whether the read data shows the raw request word or the mask word. Mask bit 31 is a master mask: while it is set, the block reports no level at all.

Top module: `irqenc_top`

## Requirements
- R1: After reset all 32 mask bits are 1, so the master mask and every source mask are set, and `level_o` is 0.
- R2: A write with `wr_set_i` sets every mask bit whose `wdata_i` bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write with `wr_clr_i` clears every mask bit whose `wdata_i` bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: If `wr_set_i` and `wr_clr_i` are both high in one cycle, a bit that is 1 in the data ends up set.
- R5: While mask bit 31 is 1, `level_o` is 0 whatever the requests and the other mask bits are.
- R6: Request bits 27, 28, 29 and 30 are the error sources: backplane async error, ECC memory error, write-buffer error and module error. Each of them gives level 15.
- R7: The onboard request bits map to levels as follows. Bit 14 and bit 15 give 12, bit 16 gives 6, bit 17 gives 13, bit 18 gives 4, bit 19 gives 10, bit 20 gives 8, bit 21 gives 9 and bit 22 gives 11. Bits 23 to 26 give no level.
- R8: Expansion-bus request n, for n from 1 to 7, is bit n+6 (bits 7 to 13). Requests 1 to 7 give levels 2, 3, 5, 7, 9, 11 and 13.
- R9: Backplane-bus request n, for n from 1 to 7, is bit n-1 (bits 0 to 6). It gives the same levels as the expansion bus: 2, 3, 5, 7, 9, 11 and 13.
- R10: `level_o` is the numerically highest level among the active sources whose mask bit is 0. Masked sources are ignored, and the output is 0 when no such source is active.
- R11: With `rd_sel_i` = 0, `rdata_o` shows the raw request word `{1'b0, req_i}` regardless of the mask. With `rd_sel_i` = 1, it shows the 32-bit mask.
- R12: `level_o` is registered. It reflects the requests and the mask as they stood at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 31 | Level-sensitive source requests, bits 0 to 30 |
| wr_set_i | input | 1 | Write strobe for the mask-set alias |
| wr_clr_i | input | 1 | Write strobe for the mask-clear alias |
| wdata_i | input | 32 | Write data; bit 31 is the master mask |
| rd_sel_i | input | 1 | Read select: 0 gives pending requests, 1 gives the mask |
| rdata_o | output | 32 | Read data |
| level_o | output | 4 | Highest unmasked active priority level; 0 means none |

## Verification
The bound checker checks the mask update on every cycle. It checks set, clear and set-wins together with the rule that zero data bits leave the mask unchanged. On every cycle it also checks that the master mask forces level 0, that the error sources give level 15, and that the output is 0 when no unmasked source is active. Only the bench scenarios show the full bit-to-level map, one source bit after another. They also show the choice of the highest level when several sources are active at once, the reset contents read back through the port, and that the pending word ignores the mask.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

    localparam int NUM_SRC  = 31;
    localparam int WORD_W   = 32;
    localparam int LVL_W    = 4;
    localparam int NUM_LVL  = 1 << LVL_W;
    localparam int MASTER_B = WORD_W - 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [LVL_W-1:0]   level_t;

    typedef struct packed {
        logic              set;
        logic              clr;
        logic [WORD_W-1:0] data;
    } mask_cmd_t;

    // Priority level given by each bus request line (1..7).
    function automatic level_t bus_level(input int n);
        case (n)
            1:       return 4'd2;
            2:       return 4'd3;
            3:       return 4'd5;
            4:       return 4'd7;
            5:       return 4'd9;
            6:       return 4'd11;
            7:       return 4'd13;
            default: return 4'd0;
        endcase
    endfunction

    // Fixed map from source bit to priority level.
    function automatic level_t src_level(input int b);
        if (b >= 27 && b <= 30) return 4'd15;
        if (b >= 7  && b <= 13) return bus_level(b - 6);
        if (b >= 0  && b <= 6)  return bus_level(b + 1);
        case (b)
            14, 15:  return 4'd12;
            16:      return 4'd6;
            17:      return 4'd13;
            18:      return 4'd4;
            19:      return 4'd10;
            20:      return 4'd8;
            21:      return 4'd9;
            22:      return 4'd11;
            default: return 4'd0;
        endcase
    endfunction

    // Set of source bits that share one level.
    function automatic src_vec_t level_members(input int lvl);
        src_vec_t v;
        v = '0;
        for (int b = 0; b < NUM_SRC; b++)
            if (int'(src_level(b)) == lvl) v[b] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/irqenc_mask_reg.sv
module irqenc_mask_reg
    import irqenc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  mask_cmd_t         cmd_i,
    output logic [WORD_W-1:0] mask_o
);

    logic [WORD_W-1:0] set_bits;
    logic [WORD_W-1:0] clr_bits;

    always_comb begin
        set_bits = cmd_i.set ? cmd_i.data : '0;
        clr_bits = cmd_i.clr ? cmd_i.data : '0;
    end

    // The clear is applied first and the set after it, so a set wins.
    always_ff @(posedge clk_i) begin
        if (rst_i) mask_o <= '1;
        else       mask_o <= (mask_o & ~clr_bits) | set_bits;
    end

endmodule

// File: rtl/irqenc_level_enc.sv
module irqenc_level_enc
    import irqenc_pkg::*;
(
    input  src_vec_t eff_i,
    output level_t   level_o
);

    logic [NUM_LVL-1:0] hit;

    assign hit[0] = 1'b0;

    generate
        for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
            localparam src_vec_t MEMBERS = level_members(l);
            assign hit[l] = |(eff_i & MEMBERS);
        end
    endgenerate

    // Walk the levels upward; the last level that hits is the highest.
    always_comb begin
        level_o = '0;
        for (int l = 1; l < NUM_LVL; l++)
            if (hit[l]) level_o = LVL_W'(l);
    end

endmodule

// File: rtl/irqenc_top.sv
module irqenc_top
    import irqenc_pkg::*;
(
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic [irqenc_pkg::NUM_SRC-1:0] req_i,
    input  logic                       wr_set_i,
    input  logic                       wr_clr_i,
    input  logic [irqenc_pkg::WORD_W-1:0]  wdata_i,
    input  logic                       rd_sel_i,
    output logic [irqenc_pkg::WORD_W-1:0]  rdata_o,
    output logic [irqenc_pkg::LVL_W-1:0]   level_o
);

    mask_cmd_t         cmd;
    logic [WORD_W-1:0] mask_q;
    src_vec_t          eff;
    level_t            level_d;

    assign cmd = '{set: wr_set_i, clr: wr_clr_i, data: wdata_i};

    irqenc_mask_reg u_mask (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .cmd_i  (cmd),
        .mask_o (mask_q)
    );

    // Only unmasked sources count, and none count while the master mask is set.
    assign eff = req_i & ~mask_q[NUM_SRC-1:0] & {NUM_SRC{~mask_q[MASTER_B]}};

    irqenc_level_enc u_enc (
        .eff_i   (eff),
        .level_o (level_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) level_o <= '0;
        else       level_o <= level_d;
    end

    assign rdata_o = rd_sel_i ? mask_q : {1'b0, req_i};

endmodule

// File: rtl/irqenc_chk.sv
module irqenc_chk
    import irqenc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input src_vec_t          req_i,
    input logic              wr_set_i,
    input logic              wr_clr_i,
    input logic [WORD_W-1:0] wdata_i,
    input logic [WORD_W-1:0] mask_q,
    input level_t            level_o
);

    // R1
    reset_mask_chk: assert property (@(posedge clk_i)
        $past(rst_i) && !rst_i |-> (mask_q == '1) && (level_o == '0));

    // R2
    set_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R3
    clr_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_clr_i && !wr_set_i |=> ((mask_q & $past(wdata_i)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_clr_i && wr_set_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R2
    keep_zero_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (((mask_q ^ $past(mask_q)) & ~($past(wdata_i)
                 & {WORD_W{$past(wr_set_i) | $past(wr_clr_i)}})) == '0));

    // R5
    master_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        mask_q[MASTER_B] |=> (level_o == '0));

    // R6
    error_top_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !mask_q[MASTER_B] && (|(req_i[30:27] & ~mask_q[30:27])) |=> (level_o == 4'd15));

    // R10
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ((req_i & ~mask_q[NUM_SRC-1:0]) == '0) |=> (level_o == '0));

endmodule

bind irqenc_top irqenc_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .req_i    (req_i),
    .wr_set_i (wr_set_i),
    .wr_clr_i (wr_clr_i),
    .wdata_i  (wdata_i),
    .mask_q   (mask_q),
    .level_o  (level_o)
);

// File: tb/irqenc_top_test.sv
module irqenc_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [30:0] req_i = '0;
    logic        wr_set_i = 1'b0;
    logic        wr_clr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        rd_sel_i = 1'b0;
    logic [31:0] rdata_o;
    logic [3:0]  level_o;

    irqenc_top uut (
        .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i),
        .wr_set_i(wr_set_i), .wr_clr_i(wr_clr_i), .wdata_i(wdata_i),
        .rd_sel_i(rd_sel_i), .rdata_o(rdata_o), .level_o(level_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [31:0] mdl_mask = '1;

    typedef struct {
        int       due;
        logic [3:0] exp;
        string    tag;
    } item_t;

    item_t sb[$];

    always @(posedge clk_i) cyc <= cyc + 1;

    // Expected level per source bit, taken from the requirement text.
    function automatic logic [3:0] lvl_of(input int b);
        int n;
        n = 0;
        if (b <= 6) n = b + 1;
        else if (b <= 13) n = b - 6;
        if (n != 0) begin
            case (n)
                1: return 4'd2;  2: return 4'd3;  3: return 4'd5;
                4: return 4'd7;  5: return 4'd9;  6: return 4'd11;
                default: return 4'd13;
            endcase
        end
        case (b)
            14, 15: return 4'd12;
            16: return 4'd6;   17: return 4'd13;
            18: return 4'd4;   19: return 4'd10;
            20: return 4'd8;   21: return 4'd9;
            22: return 4'd11;
            27, 28, 29, 30: return 4'd15;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [3:0] model(input logic [30:0] r, input logic [31:0] m);
        logic [3:0] best;
        best = 0;
        if (m[31]) return 4'd0;
        for (int b = 0; b < 31; b++)
            if (r[b] && !m[b] && lvl_of(b) > best) best = lvl_of(b);
        return best;
    endfunction

    // Monitor: pop and compare each expected item in its due cycle.
    always @(negedge clk_i) begin
        if (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (level_o !== it.exp) begin
                bad++;
                $display("FAIL %s: level actual=%0d expected=%0d", it.tag, level_o, it.exp);
            end
        end
    end

    // Driver: apply a request word and an optional mask write, then queue the result.
    task automatic drive(input logic [30:0] r, input logic s, input logic c,
                         input logic [31:0] d, input string tag);
        req_i = r; wr_set_i = s; wr_clr_i = c; wdata_i = d;
        if (c) mdl_mask = mdl_mask & ~d;
        if (s) mdl_mask = mdl_mask | d;
        sb.push_back('{due: cyc + 2, exp: model(r, mdl_mask), tag: tag});
        @(negedge clk_i);
        wr_set_i = 0; wr_clr_i = 0; wdata_i = '0;
        @(negedge clk_i);
    endtask

    task automatic read_chk(input logic sel, input logic [31:0] exp, input string tag);
        rd_sel_i = sel;
        #1;
        total++;
        if (rdata_o !== exp) begin
            bad++;
            $display("FAIL %s: rdata actual=%h expected=%h", tag, rdata_o, exp);
        end
        @(negedge clk_i);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk_i);
        rst_i = 0;
        @(negedge clk_i);
        // R1 reset state
        total++;
        if (level_o !== 4'd0) begin
            bad++; $display("FAIL R1: level actual=%0d expected=0", level_o);
        end
        read_chk(1, 32'hFFFF_FFFF, "R1 mask after reset");
        // R11 pending shows raw requests although all are masked
        req_i = 31'h5A5A_1234;
        read_chk(0, {1'b0, 31'h5A5A_1234}, "R11 pending raw");
        // R5 master still set: unmasking sources gives nothing
        drive(31'h7FFF_FFFF, 0, 1, 32'h7FFF_FFFF, "R5 master blocks");
        drive(31'h7FFF_FFFF, 1, 0, 32'h7FFF_FFFF, "R2 remask sources");
        drive(31'h7FFF_FFFF, 0, 1, 32'h8000_0000, "R2 master clear only, all masked");
        read_chk(1, 32'h7FFF_FFFF, "R3 master bit cleared");
        // Open every source; walk single request bits (R6 R7 R8 R9)
        drive(31'h0, 0, 1, 32'hFFFF_FFFF, "R3 clear all");
        read_chk(1, 32'h0, "R3 mask cleared");
        for (int b = 0; b < 31; b++) begin
            string t;
            if (b <= 6) t = $sformatf("R9 backplane bit %0d", b);
            else if (b <= 13) t = $sformatf("R8 expansion bit %0d", b);
            else if (b >= 27) t = $sformatf("R6 error bit %0d", b);
            else t = $sformatf("R7 onboard bit %0d", b);
            drive(31'(1) << b, 0, 0, '0, t);
        end
        // R10 highest of several, masking lowers it
        drive(31'h0018_0041, 0, 0, '0, "R10 highest of several");
        drive(31'h0018_0041, 1, 0, 32'h0008_0000, "R10 masked timer ignored");
        drive(31'h0018_0041, 1, 0, 32'h0010_0000, "R10 masked video ignored");
        drive(31'h0000_0000, 0, 0, '0, "R10 no request gives zero");
        // R4 set and clear same bit: set wins
        drive(31'h0008_0000, 1, 1, 32'h0008_0000, "R4 set wins");
        read_chk(1, 32'h0018_0000, "R4 mask bit stays set");
        drive(31'h0008_0000, 0, 1, 32'h0018_0000, "R3 unmask timer");
        // R5 master set with error pending
        drive(31'h4000_0000, 1, 0, 32'h8000_0000, "R5 master set with error");
        drive(31'h4000_0000, 0, 1, 32'h8000_0000, "R6 master cleared, error wins");
        // R12 output follows the request one cycle later
        req_i = 31'h0000_0001;
        @(posedge clk_i); #1;
        total++;
        if (level_o !== 4'd2) begin
            bad++; $display("FAIL R12: level actual=%0d expected=2", level_o);
        end
        @(negedge clk_i);
        repeat (3) @(negedge clk_i);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule